// File: doc/BRIEF.md
# PWM Crest/Trough Interrupt Skipper

This block sits beside a center-aligned PWM timer whose counter runs up and down. The timer hands it two event pulses: one when the counter reaches its peak (crest) and one when it reaches its valley (trough). For each kind of event the block keeps its own small counter. It passes only one event out of every programmed number of events. A passed event sets a status flag. If the interrupt for that source is enabled, the passed event also raises a one-cycle interrupt request.

The same pass decision can also gate two other pulses. The first is the qualifier that allows a buffer register to load into its compare register. The second is the qualifier that starts the A/D converter. Each source has a separate link bit for each of the two. When a link bit is set, that pulse follows the skip decision. When it is clear, the pulse fires on every event. As a result, compare reloads and converter starts can be thinned in step with the interrupts.

Software drives a small write/read register port. Through it, software sets the two 3-bit skip counts, the two skip enables, the interrupt enables and the link bits, and clears the flags.

Top module: `pwm_evt_skipper`

## Requirements
- R1: After an asynchronous active-low reset, every output pulse and flag is 0, and reading the configuration, link and status addresses (0, 1, 2) returns 0x00.
- R2: A source with its skip enable at 0, or with a skip count of 0, passes every event. A passed event produces one output pulse in the clock cycle after the event is sampled.
- R3: With the skip enable at 1 and a skip count N from 1 to 7, the source's counter advances on each event. The event that brings the count to N passes and returns the counter to zero, so exactly one event in every N passes.
- R4: Crest and trough sources keep independent counters and settings. Events of one kind never change the pass pattern of the other.
- R5: Writing a 0 into a source's enable bit clears that source's counter. After the source is enabled again, counting restarts from zero.
- R6: Configuration is at address 0, laid out as {trough enable [7], trough skip [6:4], crest enable [3], crest skip [2:0]}. A write to a skip field is ignored while that source's enable is already 1. Its enable bit still takes the written value.
- R7: The interrupt output is a one-cycle pulse. It is raised only for passed events, and only when that source's interrupt enable is 1. The interrupt enables are bit 0 (crest) and bit 1 (trough) of address 1.
- R8: The status flag is set by every passed event, whatever the interrupt enable. Writing a 1 at address 2 clears it: bit 0 for crest, bit 1 for trough. If a set and a clear occur in the same cycle, the set wins.
- R9: The buffer-transfer qualifier pulses on every event when the source's buffer link bit is 0, and only on passed events when it is 1. The buffer link bits are bit 2 (crest) and bit 3 (trough) of address 1.
- R10: The A/D trigger qualifier behaves in the same way under its own link bits: bit 4 (crest) and bit 5 (trough) of address 1.
- R11: The read data shows, without a clock delay, the register selected by the read address. Address 1 returns the six link/enable bits with bits [7:6] at 0. Address 2 returns the two flags. Address 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address for writes and reads |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the addressed register |
| crestEvt | input | 1 | Counter peak event pulse |
| troughEvt | input | 1 | Counter valley event pulse |
| crestIrq | output | 1 | Crest interrupt request pulse |
| troughIrq | output | 1 | Trough interrupt request pulse |
| crestFlag | output | 1 | Crest status flag |
| troughFlag | output | 1 | Trough status flag |
| crestBufXfer | output | 1 | Crest buffer-to-compare transfer qualifier |
| troughBufXfer | output | 1 | Trough buffer-to-compare transfer qualifier |
| crestAdcTrig | output | 1 | Crest A/D start qualifier |
| troughAdcTrig | output | 1 | Trough A/D start qualifier |

## Verification
The assertions treat events as sampled one per clock for each source. They do not depend on events being separated by any gap. Crest and trough may arrive in the same cycle, and a register write may land in the same cycle as an event. The clear-flag property assumes only that the write data and the event inputs are known during the cycle of the write. The stimulus covers directed back-to-back and spaced events, writes that collide with events, and a random phase in which any address may be written with any data. A behavioural model in the bench predicts every output and every read value on each clock.

// File: rtl/skip_pkg.sv
package skip_pkg;
  localparam int NSRC   = 2;
  localparam int SKIP_W = 3;
  localparam int FIELD_W = SKIP_W + 1;
  localparam int DATA_W = NSRC * FIELD_W;
  localparam int ADDR_W = 2;
  localparam int LINK_W = 3 * NSRC;

  localparam logic [ADDR_W-1:0] ADDR_CFG  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_LINK = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd2;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic [NSRC-1:0] evt;
    logic [NSRC-1:0] pass;
    logic [NSRC-1:0] flagClr;
  } skipStrobe_t;

  // Static gating settings
  typedef struct packed {
    logic [NSRC-1:0] adcLink;
    logic [NSRC-1:0] bufLink;
    logic [NSRC-1:0] irqEn;
  } linkCfg_t;
endpackage

// File: rtl/skip_ctrl.sv
module skip_ctrl
  import skip_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic [NSRC-1:0]       evtIn,
  output skipStrobe_t           strobe,
  output linkCfg_t              linkCfg,
  output logic [DATA_W-1:0]     cfgRd,
  output logic [DATA_W-1:0]     linkRd
);
  logic cfgWr, linkWr, statWr;
  logic [NSRC-1:0] passVec;
  logic [LINK_W-1:0] linkQ;

  assign cfgWr  = wrEn && (wrAddr == ADDR_CFG);
  assign linkWr = wrEn && (wrAddr == ADDR_LINK);
  assign statWr = wrEn && (wrAddr == ADDR_STAT);

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int BASE = i * FIELD_W;
    logic [SKIP_W-1:0] skipQ, cntQ, cntD, cntInc;
    logic enQ, passC, enWr;

    assign enWr   = wrData[BASE + SKIP_W];
    assign cntInc = cntQ + 1'b1;

    always_comb begin
      passC = 1'b0;
      cntD  = cntQ;
      if (!enQ) begin
        passC = evtIn[i];
        cntD  = '0;
      end else if (evtIn[i]) begin
        if (skipQ == '0 || cntInc == skipQ) begin
          passC = 1'b1;
          cntD  = '0;
        end else begin
          cntD = cntInc;
        end
      end
      if (cfgWr && !enWr) cntD = '0;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        enQ   <= 1'b0;
        skipQ <= '0;
        cntQ  <= '0;
      end else begin
        cntQ <= cntD;
        if (cfgWr) begin
          enQ <= enWr;
          if (!enQ) skipQ <= wrData[BASE +: SKIP_W];
        end
      end
    end

    assign passVec[i] = passC;
    assign cfgRd[BASE +: FIELD_W] = {enQ, skipQ};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       linkQ <= '0;
    else if (linkWr) linkQ <= wrData[LINK_W-1:0];
  end

  assign linkCfg = linkQ;
  assign linkRd  = DATA_W'(linkQ);

  assign strobe.evt     = evtIn;
  assign strobe.pass    = passVec;
  assign strobe.flagClr = statWr ? wrData[NSRC-1:0] : '0;
endmodule

// File: rtl/skip_dpath.sv
module skip_dpath
  import skip_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  skipStrobe_t       strobe,
  input  linkCfg_t          linkCfg,
  output logic [NSRC-1:0]   irqQ,
  output logic [NSRC-1:0]   bufQ,
  output logic [NSRC-1:0]   adcQ,
  output logic [NSRC-1:0]   flagQ,
  output logic [DATA_W-1:0] statRd
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqQ  <= '0;
      bufQ  <= '0;
      adcQ  <= '0;
      flagQ <= '0;
    end else begin
      irqQ  <= strobe.pass & linkCfg.irqEn;
      bufQ  <= strobe.pass | (strobe.evt & ~linkCfg.bufLink);
      adcQ  <= strobe.pass | (strobe.evt & ~linkCfg.adcLink);
      flagQ <= (flagQ & ~strobe.flagClr) | strobe.pass;
    end
  end

  assign statRd = DATA_W'(flagQ);
endmodule

// File: rtl/pwm_evt_skipper.sv
module pwm_evt_skipper
  import skip_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regAddr,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic        crestEvt,
  input  logic        troughEvt,
  output logic        crestIrq,
  output logic        troughIrq,
  output logic        crestFlag,
  output logic        troughFlag,
  output logic        crestBufXfer,
  output logic        troughBufXfer,
  output logic        crestAdcTrig,
  output logic        troughAdcTrig
);
  skipStrobe_t strobe;
  linkCfg_t linkCfg;
  logic [DATA_W-1:0] cfgRd, linkRd, statRd;
  logic [NSRC-1:0] irqQ, bufQ, adcQ, flagQ;

  skip_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .wrAddr(regAddr),
    .wrData(regWrData), .evtIn({troughEvt, crestEvt}),
    .strobe(strobe), .linkCfg(linkCfg), .cfgRd(cfgRd), .linkRd(linkRd)
  );

  skip_dpath dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .linkCfg(linkCfg),
    .irqQ(irqQ), .bufQ(bufQ), .adcQ(adcQ), .flagQ(flagQ), .statRd(statRd)
  );

  always_comb begin
    case (regAddr)
      ADDR_CFG:  regRdData = cfgRd;
      ADDR_LINK: regRdData = linkRd;
      ADDR_STAT: regRdData = statRd;
      default:   regRdData = '0;
    endcase
  end

  assign crestIrq      = irqQ[0];
  assign troughIrq     = irqQ[1];
  assign crestFlag     = flagQ[0];
  assign troughFlag    = flagQ[1];
  assign crestBufXfer  = bufQ[0];
  assign troughBufXfer = bufQ[1];
  assign crestAdcTrig  = adcQ[0];
  assign troughAdcTrig = adcQ[1];
endmodule

// File: rtl/pwm_evt_skipper_chk.sv
module pwm_evt_skipper_chk (
  input logic clk,
  input logic rstN,
  input logic statWr,
  input logic clrCrest,
  input logic clrTrough,
  input logic crestEvt,
  input logic troughEvt,
  input logic crestIrq,
  input logic troughIrq,
  input logic crestFlag,
  input logic troughFlag,
  input logic crestBufXfer,
  input logic troughBufXfer,
  input logic crestAdcTrig,
  input logic troughAdcTrig
);
  // R7
  crest_irq_follows_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    crestIrq |-> $past(crestEvt));
  // R7
  trough_irq_follows_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    troughIrq |-> $past(troughEvt));
  // R8
  crest_irq_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    crestIrq |-> crestFlag);
  // R8
  trough_flag_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(troughFlag) |-> $past(troughEvt));
  // R8
  crest_flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && clrCrest && !crestEvt) |=> !crestFlag);
  // R8
  trough_flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statWr && clrTrough && !troughEvt) |=> !troughFlag);
  // R9
  crest_buf_follows_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    crestBufXfer |-> $past(crestEvt));
  // R9
  trough_irq_implies_buf_chk: assert property (@(posedge clk) disable iff (!rstN)
    troughIrq |-> troughBufXfer);
  // R10
  crest_irq_implies_adc_chk: assert property (@(posedge clk) disable iff (!rstN)
    crestIrq |-> crestAdcTrig);
  // R10
  trough_adc_follows_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    troughAdcTrig |-> $past(troughEvt));
endmodule

bind pwm_evt_skipper pwm_evt_skipper_chk chk_i (
  .clk(clk), .rstN(rstN),
  .statWr(regWrEn && (regAddr == 2'd2)),
  .clrCrest(regWrData[0]), .clrTrough(regWrData[1]),
  .crestEvt(crestEvt), .troughEvt(troughEvt),
  .crestIrq(crestIrq), .troughIrq(troughIrq),
  .crestFlag(crestFlag), .troughFlag(troughFlag),
  .crestBufXfer(crestBufXfer), .troughBufXfer(troughBufXfer),
  .crestAdcTrig(crestAdcTrig), .troughAdcTrig(troughAdcTrig)
);

// File: tb/pwm_evt_skipper_tb_top.sv
`timescale 1ns/1ps
module pwm_evt_skipper_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWrData = 8'd0;
  logic [7:0] regRdData;
  logic crestEvt = 1'b0, troughEvt = 1'b0;
  logic crestIrq, troughIrq, crestFlag, troughFlag;
  logic crestBufXfer, troughBufXfer, crestAdcTrig, troughAdcTrig;

  int nTests = 0;
  int nFail = 0;
  bit done = 0;

  // behavioural model state
  int mSkip[2], mEn[2], mCnt[2], mIrqEn[2], mBufL[2], mAdcL[2], mFlag[2];
  int eIrq[2], eBuf[2], eAdc[2];
  int irqSeen[2], bufSeen[2], adcSeen[2];

  always #10 clk = ~clk;

  pwm_evt_skipper dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .crestEvt(crestEvt), .troughEvt(troughEvt),
    .crestIrq(crestIrq), .troughIrq(troughIrq),
    .crestFlag(crestFlag), .troughFlag(troughFlag),
    .crestBufXfer(crestBufXfer), .troughBufXfer(troughBufXfer),
    .crestAdcTrig(crestAdcTrig), .troughAdcTrig(troughAdcTrig)
  );

  task automatic check(input string tag, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 2; i++) begin
      mSkip[i] = 0; mEn[i] = 0; mCnt[i] = 0; mIrqEn[i] = 0;
      mBufL[i] = 0; mAdcL[i] = 0; mFlag[i] = 0;
      eIrq[i] = 0; eBuf[i] = 0; eAdc[i] = 0;
    end
  endtask

  function automatic int modelRead(input int a);
    case (a)
      0: return (mEn[1] << 7) | (mSkip[1] << 4) | (mEn[0] << 3) | mSkip[0];
      1: return (mAdcL[1] << 5) | (mAdcL[0] << 4) | (mBufL[1] << 3) |
                (mBufL[0] << 2) | (mIrqEn[1] << 1) | mIrqEn[0];
      2: return (mFlag[1] << 1) | mFlag[0];
      default: return 0;
    endcase
  endfunction

  task automatic modelStep(input int ev0, input int ev1, input int w,
                           input int a, input int d);
    int ev[2];
    int pass;
    int en;
    ev[0] = ev0; ev[1] = ev1;
    for (int i = 0; i < 2; i++) begin
      pass = 0;
      if (mEn[i] == 0) begin
        pass = ev[i]; mCnt[i] = 0;
      end else if (ev[i] != 0) begin
        if (mSkip[i] == 0 || mCnt[i] + 1 == mSkip[i]) begin
          pass = 1; mCnt[i] = 0;
        end else mCnt[i]++;
      end
      eIrq[i] = pass & mIrqEn[i];
      eBuf[i] = pass | (ev[i] & (1 - mBufL[i]));
      eAdc[i] = pass | (ev[i] & (1 - mAdcL[i]));
      if (w != 0 && a == 2 && ((d >> i) & 1) != 0) mFlag[i] = 0;
      if (pass != 0) mFlag[i] = 1;
      if (w != 0 && a == 0) begin
        en = (d >> (4 * i + 3)) & 1;
        if (mEn[i] == 0) mSkip[i] = (d >> (4 * i)) & 7;
        if (en == 0) mCnt[i] = 0;
        mEn[i] = en;
      end
    end
    if (w != 0 && a == 1) begin
      for (int i = 0; i < 2; i++) begin
        mIrqEn[i] = (d >> i) & 1;
        mBufL[i]  = (d >> (2 + i)) & 1;
        mAdcL[i]  = (d >> (4 + i)) & 1;
      end
    end
  endtask

  task automatic compareAll();
    check("R7 crest irq", crestIrq, eIrq[0]);
    check("R7 trough irq", troughIrq, eIrq[1]);
    check("R8 crest flag", crestFlag, mFlag[0]);
    check("R8 trough flag", troughFlag, mFlag[1]);
    check("R9 crest buf", crestBufXfer, eBuf[0]);
    check("R9 trough buf", troughBufXfer, eBuf[1]);
    check("R10 crest adc", crestAdcTrig, eAdc[0]);
    check("R10 trough adc", troughAdcTrig, eAdc[1]);
    check("R11 read data", regRdData, modelRead(regAddr));
    irqSeen[0] += crestIrq;     irqSeen[1] += troughIrq;
    bufSeen[0] += crestBufXfer; bufSeen[1] += troughBufXfer;
    adcSeen[0] += crestAdcTrig; adcSeen[1] += troughAdcTrig;
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit ce, input bit te, input bit w,
                     input logic [1:0] a, input logic [7:0] d);
    crestEvt = ce; troughEvt = te; regWrEn = w; regAddr = a; regWrData = d;
    @(posedge clk);
    modelStep(int'(ce), int'(te), int'(w), int'(a), int'(d));
    @(negedge clk);
    compareAll();
  endtask

  task automatic idle(input logic [1:0] a);
    cyc(1'b0, 1'b0, 1'b0, a, 8'd0);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cyc(1'b0, 1'b0, 1'b1, a, d);
  endtask

  task automatic clearSeen();
    for (int i = 0; i < 2; i++) begin
      irqSeen[i] = 0; bufSeen[i] = 0; adcSeen[i] = 0;
    end
  endtask

  initial begin
    modelReset();
    clearSeen();
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 outputs", {crestIrq, troughIrq, crestFlag, troughFlag,
          crestBufXfer, troughBufXfer, crestAdcTrig, troughAdcTrig}, 0);
    rstN = 1'b1;
    for (int a = 0; a < 3; a++) begin
      idle(2'(a));
      check("R1 readback", regRdData, 0);
    end

    // R2: enable off passes every event
    wr(2'd1, 8'h03);
    clearSeen();
    for (int k = 0; k < 5; k++) cyc(1'b1, 1'b0, 1'b0, 2'd0, 8'd0);
    idle(2'd0);
    check("R2 crest passes with enable off", irqSeen[0], 5);
    // R2: enabled with skip 0 passes every event
    wr(2'd0, 8'h88);
    clearSeen();
    for (int k = 0; k < 4; k++) begin
      cyc(1'b0, 1'b1, 1'b0, 2'd0, 8'd0);
      idle(2'd0);
    end
    check("R2 trough passes with skip 0", irqSeen[1], 4);

    // R6: skip field write ignored while enabled
    wr(2'd0, 8'hDD);
    idle(2'd0);
    check("R6 skip locked while enabled", regRdData, 8'h88);

    // R3 / R4: crest skip 3, trough skip 2
    wr(2'd0, 8'h00);
    wr(2'd0, 8'hAB);
    idle(2'd0);
    check("R6 skip written while disabled", regRdData, 8'hAB);
    clearSeen();
    for (int k = 0; k < 21; k++) begin
      cyc(1'b1, k < 10, 1'b0, 2'd0, 8'd0);
      if (k % 3 == 0) idle(2'd0);
    end
    idle(2'd0);
    check("R3 crest one per three", irqSeen[0], 7);
    check("R4 trough independent one per two", irqSeen[1], 5);

    // R5: disabling clears the counter
    clearSeen();
    cyc(1'b1, 1'b0, 1'b0, 2'd0, 8'd0);
    cyc(1'b1, 1'b0, 1'b0, 2'd0, 8'd0);
    wr(2'd0, 8'hA3);
    wr(2'd0, 8'hAB);
    cyc(1'b1, 1'b0, 1'b0, 2'd0, 8'd0);
    cyc(1'b1, 1'b0, 1'b0, 2'd0, 8'd0);
    idle(2'd0);
    check("R5 counter restarted", irqSeen[0], 0);
    cyc(1'b1, 1'b0, 1'b0, 2'd0, 8'd0);
    idle(2'd0);
    check("R5 pass after fresh count", irqSeen[0], 1);

    // R7 / R8: irq masked, flag still set, clear and set-wins
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h03);
    clearSeen();
    cyc(1'b1, 1'b1, 1'b0, 2'd2, 8'd0);
    idle(2'd2);
    check("R7 masked irq silent", irqSeen[0] + irqSeen[1], 0);
    check("R8 flags set while masked", regRdData, 3);
    wr(2'd2, 8'h01);
    check("R8 crest cleared trough kept", {crestFlag, troughFlag}, 2'b01);
    cyc(1'b0, 1'b1, 1'b1, 2'd2, 8'h02);
    check("R8 set wins over clear", troughFlag, 1);

    // R9 / R10: linked qualifiers
    wr(2'd0, 8'h0B);
    wr(2'd1, 8'h3C);
    clearSeen();
    for (int k = 0; k < 6; k++) begin
      cyc(1'b1, 1'b0, 1'b0, 2'd1, 8'd0);
      idle(2'd1);
    end
    check("R9 linked buf follows skip", bufSeen[0], 2);
    check("R10 linked adc follows skip", adcSeen[0], 2);
    wr(2'd1, 8'h0C);
    clearSeen();
    for (int k = 0; k < 6; k++) cyc(1'b1, 1'b0, 1'b0, 2'd1, 8'd0);
    idle(2'd1);
    check("R10 unlinked adc every event", adcSeen[0], 6);
    check("R9 linked buf still skips", bufSeen[0], 2);

    // random phase: model compared every clock (R2..R11)
    for (int k = 0; k < 3000; k++) begin
      bit w;
      w = ($urandom_range(0, 7) == 0);
      cyc(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), w,
          2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule